// File: doc/BRIEF.md
# OTP Fuse Command Sequencer

This block sits between a 32-bit register port and a one-time-programmable fuse array. The array is modelled inside the block as a small bank of 32-bit words that start at zero. Software first asks for array power and waits for the powered flag. It then starts operations by writing a single control register. Each operation runs for a fixed number of cycles while a busy flag is up. Its result lands at the moment busy drops.

Three operations exist. A shadow read copies a fuse word into that word's shadow data register, which software can read at any time without a command. A program ORs a previously written data word into a fuse word. A permanent-lock program sets the word's program lock. A program is refused when the global program lock is set or the word's own lock is set. A refused program raises a sticky fail flag and a per-word error flag. Per-word locks and flags are packed 32 words to a bank word.

Top module: `otp_seq_ctrl`

## Requirements
- R1: After reset every readable register returns zero: configuration, status, write data, global lock, all flag and lock banks and all shadow words.
- R2: Status bit 5 (power on) goes high PWR_DELAY clock edges after configuration bit 0 (offset 0x000) is written to 1. It goes low PWR_DELAY edges after that bit is cleared, provided no operation is in progress. Status bits 6 and 7 always read 0.
- R3: A write to the control register (offset 0x004) is ignored when status bit 5 is low, or while status bit 3 (busy) is high. Ignored means busy does not rise and no fuse, shadow or flag changes.
- R4: An accepted command holds status bit 3 high for exactly BUSY_CYCLES cycles. While busy, status bits [2:0] show 1 for shadow read, 2 for program and 3 for permanent lock. They show 0 when idle.
- R5: The control word carries the word index in its low bits. Bit 8 alone selects program, bits 8 and 9 together select permanent lock, and bit 8 clear (whatever bit 9 holds) selects shadow read.
- R6: When a shadow read of word N completes, the shadow register at offset 0x200 + 4*N takes the fuse word. Shadow registers change only on a shadow read.
- R7: When a program of word N completes, the fuse word becomes its old value ORed with the write-data register (offset 0x008) as it stood at acceptance. Bits therefore only go from 0 to 1.
- R8: A program fails when global lock bit 3 (offset 0x010) is set or word N's program-lock bit is set. A failure leaves the fuse word unchanged, sets status bit 4 and sets error bit N mod 32 in the error bank word at 0x020 + 4*(N/32).
- R9: A permanent-lock command on word N sets bit N mod 32 of the program-lock bank at 0x060 + 4*(N/32), unless the global lock is set, in which case it fails like R8.
- R10: A shadow read of a word whose read-lock bit is set (bank at 0x080 + 4*(N/32)) leaves the shadow register unchanged. It sets disturbed bit N mod 32 in the bank at 0x040 + 4*(N/32).
- R11: Lock banks and the global lock are write-one-to-set: writing 0 to a bit never clears it.
- R12: Status bit 4 clears when the next command is accepted.
- R13: Clearing the power request while an operation is busy does not drop power before busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
The bench builds the block with NWORDS=64, BUSY_CYCLES=3 and PWR_DELAY=2. The 64-word array gives two flag banks, so bank-offset and bit-position decoding is exercised on both sides of the 32-word boundary (words 10 and 33). The short busy and power delays let every edge of the busy window and of the power handshake, including power-down held off by busy, be sampled cycle by cycle.

// File: rtl/otpc_pkg.sv
package otpc_pkg;

   typedef enum logic [2:0] {
      MODE_IDLE = 3'd0,
      MODE_READ = 3'd1,
      MODE_PROG = 3'd2,
      MODE_LOCK = 3'd3
   } otpc_mode_e;

   localparam int unsigned CTRL_PROG_BIT  = 8;
   localparam int unsigned CTRL_LOCK_BIT  = 9;
   localparam int unsigned GLOCK_PROG_BIT = 3;

   localparam logic [11:0] ADDR_CFG    = 12'h000;
   localparam logic [11:0] ADDR_CTRL   = 12'h004;
   localparam logic [11:0] ADDR_WDATA  = 12'h008;
   localparam logic [11:0] ADDR_STATUS = 12'h00C;
   localparam logic [11:0] ADDR_GLOCK  = 12'h010;

   // region selector is reg_addr[11:5]; bank index is reg_addr[4:2]
   localparam logic [6:0] REGION_ERR   = 7'd1;
   localparam logic [6:0] REGION_DIST  = 7'd2;
   localparam logic [6:0] REGION_PLOCK = 7'd3;
   localparam logic [6:0] REGION_RLOCK = 7'd4;

   function automatic otpc_mode_e decode_op(input logic prog, input logic lock);
      if (!prog)     return MODE_READ;
      else if (lock) return MODE_LOCK;
      else           return MODE_PROG;
   endfunction

endpackage

// File: rtl/otpc_power.sv
module otpc_power #(
   parameter int unsigned DELAY = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic hold_on,
   output logic on
);
   localparam int unsigned CW = $clog2(DELAY + 1);

   logic [CW-1:0] cnt;
   logic          moving;

   initial begin
      assert (DELAY >= 1) else $error("DELAY must be at least 1");
   end

   assign moving = (req != on) && !(on && hold_on);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on  <= 1'b0;
         cnt <= '0;
      end else if (moving) begin
         if (cnt == CW'(DELAY - 1)) begin
            on  <= req;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt <= '0;
      end
   end

   assert_power_follows_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on) |-> $past(req));

   assert_power_drops_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(on) |-> !$past(req));

   assert_power_held_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (on && hold_on) |=> on);

endmodule

// File: rtl/otpc_engine.sv
module otpc_engine
   import otpc_pkg::*;
#(
   parameter int unsigned IDX_W       = 6,
   parameter int unsigned BUSY_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [IDX_W-1:0] cmd_idx,
   input  logic             cmd_prog,
   input  logic             cmd_lock,
   input  logic             pwr_on,
   output logic             accept,
   output logic             busy,
   output logic             done,
   output otpc_mode_e       op,
   output otpc_mode_e       mode,
   output logic [IDX_W-1:0] op_idx
);
   localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

   logic [CW-1:0] cnt;

   initial begin
      assert (BUSY_CYCLES >= 1) else $error("BUSY_CYCLES must be at least 1");
   end

   assign accept = cmd_we && pwr_on && !busy;
   assign done   = busy && (cnt == '0);
   assign mode   = busy ? op : MODE_IDLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         op     <= MODE_IDLE;
         op_idx <= '0;
      end else if (accept) begin
         busy   <= 1'b1;
         cnt    <= CW'(BUSY_CYCLES - 1);
         op     <= decode_op(cmd_prog, cmd_lock);
         op_idx <= cmd_idx;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   // checker-side window counter for the busy length
   logic [CW:0] busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1'b1;
      else           busy_len <= '0;
   end

   assert_busy_not_too_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < (CW+1)'(BUSY_CYCLES)));

   assert_busy_full_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(busy_len) == (CW+1)'(BUSY_CYCLES - 1)));

   assert_cmd_needs_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !pwr_on && !busy) |=> !busy);

   assert_mode_idle_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mode == MODE_IDLE));

endmodule

// File: rtl/otpc_bitbank.sv
module otpc_bitbank #(
   parameter int unsigned NWORDS = 64,
   parameter bit          SW_SET = 1'b0,
   localparam int unsigned IDX_W  = $clog2(NWORDS),
   localparam int unsigned NBANKS = NWORDS / 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [2:0]        sw_bank,
   input  logic [31:0]       sw_mask,
   input  logic              hw_set,
   input  logic [IDX_W-1:0]  hw_idx,
   output logic [NWORDS-1:0] bits
);
   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic [31:0] sw_part;
      logic [31:0] hw_part;

      if (SW_SET) begin : g_sw
         assign sw_part = (sw_we && sw_bank == 3'(b)) ? sw_mask : 32'h0;
      end else begin : g_hw_only
         assign sw_part = 32'h0;
      end

      assign hw_part = (hw_set && (hw_idx[IDX_W-1:5] == (IDX_W-5)'(b)))
                       ? (32'h1 << hw_idx[4:0]) : 32'h0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bits[b*32 +: 32] <= 32'h0;
         else        bits[b*32 +: 32] <= bits[b*32 +: 32] | sw_part | hw_part;
      end
   end

   assert_bits_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((bits & $past(bits)) == $past(bits)));

endmodule

// File: rtl/otp_seq_ctrl.sv
module otp_seq_ctrl
   import otpc_pkg::*;
#(
   parameter int unsigned NWORDS      = 64,
   parameter int unsigned BUSY_CYCLES = 4,
   parameter int unsigned PWR_DELAY   = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [11:0] reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata
);
   localparam int unsigned IDX_W  = $clog2(NWORDS);
   localparam int unsigned NBANKS = NWORDS / 32;

   initial begin
      assert (NWORDS == 32 || NWORDS == 64 || NWORDS == 128)
         else $error("NWORDS must be 32, 64 or 128");
   end

   logic              aligned;
   logic [6:0]        region;
   logic [2:0]        bank_sel;
   logic              shadow_hit;
   logic              ctrl_we;

   logic              pwr_req_q;
   logic              pwr_on;
   logic [31:0]       wdata_q;
   logic [31:0]       prog_data_q;
   logic              glock_q;
   logic              fail_q;

   logic              accept, busy, done;
   otpc_mode_e        op, mode;
   logic [IDX_W-1:0]  op_idx;

   logic [NWORDS-1:0] err_bits, dist_bits, plock_bits, rlock_bits;
   logic [31:0]       fuse   [NWORDS];
   logic [31:0]       shadow [NWORDS];

   logic              rd_done, prog_done, lock_done;
   logic              prog_blocked, fail_set;

   assign aligned    = (reg_addr[1:0] == 2'b00);
   assign region     = reg_addr[11:5];
   assign bank_sel   = reg_addr[4:2];
   assign shadow_hit = aligned && (reg_addr[11:9] == 3'b001) && (int'(reg_addr[8:2]) < NWORDS);
   assign ctrl_we    = reg_we && (reg_addr == ADDR_CTRL);

   otpc_power #(.DELAY(PWR_DELAY)) u_power (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (pwr_req_q),
      .hold_on (busy),
      .on      (pwr_on)
   );

   otpc_engine #(.IDX_W(IDX_W), .BUSY_CYCLES(BUSY_CYCLES)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (ctrl_we),
      .cmd_idx  (reg_wdata[IDX_W-1:0]),
      .cmd_prog (reg_wdata[CTRL_PROG_BIT]),
      .cmd_lock (reg_wdata[CTRL_LOCK_BIT]),
      .pwr_on   (pwr_on),
      .accept   (accept),
      .busy     (busy),
      .done     (done),
      .op       (op),
      .mode     (mode),
      .op_idx   (op_idx)
   );

   assign rd_done      = done && (op == MODE_READ);
   assign prog_done    = done && (op == MODE_PROG);
   assign lock_done    = done && (op == MODE_LOCK);
   assign prog_blocked = glock_q || plock_bits[op_idx];
   assign fail_set     = (prog_done && prog_blocked) || (lock_done && glock_q);

   otpc_bitbank #(.NWORDS(NWORDS), .SW_SET(1'b0)) u_err (
      .clk(clk), .rst_n(rst_n), .sw_we(1'b0), .sw_bank(bank_sel), .sw_mask(reg_wdata),
      .hw_set(fail_set), .hw_idx(op_idx), .bits(err_bits)
   );

   otpc_bitbank #(.NWORDS(NWORDS), .SW_SET(1'b0)) u_dist (
      .clk(clk), .rst_n(rst_n), .sw_we(1'b0), .sw_bank(bank_sel), .sw_mask(reg_wdata),
      .hw_set(rd_done && rlock_bits[op_idx]), .hw_idx(op_idx), .bits(dist_bits)
   );

   otpc_bitbank #(.NWORDS(NWORDS), .SW_SET(1'b1)) u_plock (
      .clk(clk), .rst_n(rst_n),
      .sw_we(reg_we && aligned && region == REGION_PLOCK), .sw_bank(bank_sel), .sw_mask(reg_wdata),
      .hw_set(lock_done && !glock_q), .hw_idx(op_idx), .bits(plock_bits)
   );

   otpc_bitbank #(.NWORDS(NWORDS), .SW_SET(1'b1)) u_rlock (
      .clk(clk), .rst_n(rst_n),
      .sw_we(reg_we && aligned && region == REGION_RLOCK), .sw_bank(bank_sel), .sw_mask(reg_wdata),
      .hw_set(1'b0), .hw_idx(op_idx), .bits(rlock_bits)
   );

   // software-visible control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_req_q   <= 1'b0;
         wdata_q     <= 32'h0;
         prog_data_q <= 32'h0;
         glock_q     <= 1'b0;
         fail_q      <= 1'b0;
      end else begin
         if (reg_we && reg_addr == ADDR_CFG)   pwr_req_q <= reg_wdata[0];
         if (reg_we && reg_addr == ADDR_WDATA) wdata_q   <= reg_wdata;
         if (reg_we && reg_addr == ADDR_GLOCK && reg_wdata[GLOCK_PROG_BIT]) glock_q <= 1'b1;
         if (accept)        prog_data_q <= wdata_q;
         if (accept)        fail_q      <= 1'b0;
         else if (fail_set) fail_q      <= 1'b1;
      end
   end

   // fuse model and shadow copies
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < NWORDS; w++) begin
            fuse[w]   <= 32'h0;
            shadow[w] <= 32'h0;
         end
      end else begin
         if (prog_done && !prog_blocked)
            fuse[op_idx] <= fuse[op_idx] | prog_data_q;
         if (rd_done && !rlock_bits[op_idx])
            shadow[op_idx] <= fuse[op_idx];
      end
   end

   function automatic logic [31:0] bank_word(input logic [NWORDS-1:0] v, input logic [2:0] b);
      logic [31:0] r;
      r = 32'h0;
      for (int k = 0; k < NBANKS; k++)
         if (b == 3'(k)) r = v[k*32 +: 32];
      return r;
   endfunction

   always_comb begin
      reg_rdata = 32'h0;
      if (shadow_hit) begin
         reg_rdata = shadow[reg_addr[IDX_W+1:2]];
      end else if (aligned) begin
         unique case (region)
            REGION_ERR:   reg_rdata = bank_word(err_bits,   bank_sel);
            REGION_DIST:  reg_rdata = bank_word(dist_bits,  bank_sel);
            REGION_PLOCK: reg_rdata = bank_word(plock_bits, bank_sel);
            REGION_RLOCK: reg_rdata = bank_word(rlock_bits, bank_sel);
            default: begin
               case (reg_addr)
                  ADDR_CFG:    reg_rdata = {31'h0, pwr_req_q};
                  ADDR_WDATA:  reg_rdata = wdata_q;
                  ADDR_STATUS: reg_rdata = {26'h0, pwr_on, fail_q, busy, mode};
                  ADDR_GLOCK:  reg_rdata = 32'(glock_q) << GLOCK_PROG_BIT;
                  default:     reg_rdata = 32'h0;
               endcase
            end
         endcase
      end
   end

   assert_busy_needs_power_R13: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> pwr_on);

   assert_fail_at_completion_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_q) |-> $fell(busy));

   assert_fail_clears_on_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !fail_q);

   assert_fuse_only_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ((fuse[$past(op_idx)] & $past(fuse[op_idx])) == $past(fuse[op_idx])));

endmodule

// File: tb/tb_otp_seq_ctrl.sv
module tb_otp_seq_ctrl;
   localparam int unsigned NW    = 64;
   localparam int unsigned BUSY  = 3;
   localparam int unsigned PWR   = 2;

   localparam logic [11:0] A_CFG = 12'h000, A_CTRL = 12'h004, A_WD = 12'h008,
                           A_ST  = 12'h00C, A_GL   = 12'h010;
   localparam logic [11:0] A_ERR = 12'h020, A_DIST = 12'h040, A_PL = 12'h060,
                           A_RL  = 12'h080, A_SH   = 12'h200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = 12'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   otp_seq_ctrl #(.NWORDS(NW), .BUSY_CYCLES(BUSY), .PWR_DELAY(PWR)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   typedef struct packed {
      logic [7:0]  idx;
      logic [31:0] data;
      logic [31:0] expect_word;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{8'd5,  32'h0000_00F0, 32'h0000_00F0},
      '{8'd5,  32'h0000_0F0F, 32'h0000_0FFF},
      '{8'd40, 32'hA5A5_0000, 32'hA5A5_0000},
      '{8'd63, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      '{8'd0,  32'h0000_0001, 32'h0000_0001},
      '{8'd5,  32'h0000_0000, 32'h0000_0FFF}
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // status: pwr bit5, fail bit4, busy bit3, mode [2:0]
   task automatic run_cmd(input string req, input logic [31:0] ctrl, input logic [2:0] mode_exp);
      logic [31:0] s;
      wr(A_CTRL, ctrl);
      rd(A_ST, s);
      chk(req, {28'h0, s[3], s[2:0]}, {28'h0, 1'b1, mode_exp});
      repeat (BUSY - 1) @(negedge clk);
      rd(A_ST, s);
      chk(req, {31'h0, s[3]}, 32'h1);
      @(negedge clk);
      rd(A_ST, s);
      chk(req, {28'h0, s[3], s[2:0]}, 32'h0);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      @(negedge clk);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_ST, v);             chk("R1 status", v, 32'h0);
      rd(A_CFG, v);            chk("R1 cfg", v, 32'h0);
      rd(A_WD, v);             chk("R1 wdata", v, 32'h0);
      rd(A_GL, v);             chk("R1 glock", v, 32'h0);
      rd(A_ERR + 12'h4, v);    chk("R1 err bank1", v, 32'h0);
      rd(A_PL, v);             chk("R1 plock bank0", v, 32'h0);
      rd(A_SH + 12'd252, v);   chk("R1 shadow63", v, 32'h0);

      // R3 command with power off is ignored
      wr(A_WD, 32'h0000_00FF);
      wr(A_CTRL, 32'h0000_0107);
      rd(A_ST, v);             chk("R3 no busy unpowered", v, 32'h0);
      repeat (BUSY + 1) @(negedge clk);

      // R2 power-up timing
      wr(A_CFG, 32'h1);
      rd(A_ST, v);             chk("R2 not yet on", {31'h0, v[5]}, 32'h0);
      @(negedge clk);
      rd(A_ST, v);             chk("R2 still off", {31'h0, v[5]}, 32'h0);
      @(negedge clk);
      rd(A_ST, v);             chk("R2 powered", v, 32'h0000_0020);

      // word 7 never programmed by the ignored command
      run_cmd("R3 read word7", 32'h7, 3'd1);
      rd(A_SH + 12'd28, v);    chk("R3 word7 untouched", v, 32'h0);

      // R5 R6 R7 vector table
      for (int i = 0; i < 6; i++) begin
         wr(A_WD, VEC[i].data);
         run_cmd("R5 R7 program", {22'h0, 2'b01, VEC[i].idx}, 3'd2);
         if (i == 0) begin
            rd(A_SH + 12'd20, v); chk("R6 shadow waits for read", v, 32'h0);
         end
         run_cmd("R6 read", {24'h0, VEC[i].idx}, 3'd1);
         rd(A_SH + {2'b00, VEC[i].idx, 2'b00}, v);
         chk("R7 fuse OR result", v, VEC[i].expect_word);
      end

      // R3 command during busy ignored; R5 bit9 alone decodes as read
      wr(A_WD, 32'h0000_0055);
      wr(A_CTRL, 32'h0000_023F);
      rd(A_ST, v);             chk("R5 bit9 alone is read", v, 32'h0000_0029);
      wr(A_CTRL, 32'h0000_0102);
      repeat (BUSY) @(negedge clk);
      rd(A_ST, v);             chk("R3 second command dropped", v, 32'h0000_0020);
      run_cmd("R3 read word2", 32'h2, 3'd1);
      rd(A_SH + 12'd8, v);     chk("R3 word2 not programmed", v, 32'h0);

      // R8 R11 per-word program lock via register
      wr(A_PL, 32'h0000_0400);
      wr(A_PL, 32'h0);
      rd(A_PL, v);             chk("R11 plock sticky", v, 32'h0000_0400);
      wr(A_WD, 32'h0000_00FF);
      run_cmd("R8 program locked word10", 32'h10A, 3'd2);
      rd(A_ST, v);             chk("R8 fail flag", v, 32'h0000_0030);
      rd(A_ERR, v);            chk("R8 error bank0", v, 32'h0000_0400);
      // R12 next accepted command clears fail
      wr(A_CTRL, 32'h0000_000A);
      rd(A_ST, v);             chk("R12 fail cleared", v, 32'h0000_0029);
      repeat (BUSY) @(negedge clk);
      rd(A_SH + 12'd40, v);    chk("R8 word10 unchanged", v, 32'h0);

      // R9 permanent lock of word 33 then failing program
      run_cmd("R9 lock word33", 32'h0000_0321, 3'd3);
      rd(A_PL + 12'h4, v);     chk("R9 plock bank1", v, 32'h0000_0002);
      rd(A_ST, v);             chk("R9 lock ok no fail", v, 32'h0000_0020);
      wr(A_WD, 32'h0000_0001);
      run_cmd("R8 program word33", 32'h0000_0121, 3'd2);
      rd(A_ERR + 12'h4, v);    chk("R8 error bank1", v, 32'h0000_0002);
      run_cmd("R8 read word33", 32'h21, 3'd1);
      rd(A_SH + 12'd132, v);   chk("R8 word33 unchanged", v, 32'h0);

      // R10 read lock on word 5
      wr(A_RL, 32'h0000_0020);
      wr(A_WD, 32'h0000_F000);
      run_cmd("R10 program word5", 32'h105, 3'd2);
      run_cmd("R10 locked read", 32'h5, 3'd1);
      rd(A_SH + 12'd20, v);    chk("R10 shadow kept", v, 32'h0000_0FFF);
      rd(A_DIST, v);           chk("R10 disturbed bank0", v, 32'h0000_0020);

      // R8 R11 global lock
      wr(A_GL, 32'h0000_0008);
      wr(A_GL, 32'h0);
      rd(A_GL, v);             chk("R11 glock sticky", v, 32'h0000_0008);
      wr(A_WD, 32'h0000_0010);
      run_cmd("R8 global lock program", 32'h101, 3'd2);
      rd(A_ST, v);             chk("R8 global fail", v, 32'h0000_0030);
      rd(A_ERR, v);            chk("R8 error word1", v, 32'h0000_0402);

      // R13 power-down request held off by busy
      wr(A_CTRL, 32'h0000_0000);
      wr(A_CFG, 32'h0);
      @(negedge clk);
      rd(A_ST, v);             chk("R13 on while busy", {30'h0, v[5], v[3]}, 32'h3);
      @(negedge clk);
      rd(A_ST, v);             chk("R13 on at busy end", {30'h0, v[5], v[3]}, 32'h2);
      repeat (PWR) @(negedge clk);
      rd(A_ST, v);             chk("R2 powered down", v, 32'h0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule